// File: doc/BRIEF.md
# Load Data Extract and Extend Unit

This combinational unit sits between the data memory read port and the register writeback path of a processor core. The memory always returns one aligned 32-bit word. The unit uses the low two bits of the byte address and the three-bit load function code to pick the addressed byte or halfword out of that word. It then widens the picked value to a full register: by sign extension for the signed loads and by zero extension for the unsigned loads.

The memory is byte-addressed and little-endian. Byte lane 0 is therefore the least significant byte of the word. A full-word load passes the word through untouched. A function code that is not a load size falls back to the raw word.

Top module: `ld_extend_unit`

## Requirements
- R1: When `ld_funct3` = 3'b010 (word load), `ld_result` equals `mem_word` exactly.
- R2: When `ld_funct3` = 3'b000 (signed byte load), `ld_result[7:0]` is the selected byte and bits 31:8 are copies of that byte's bit 7.
- R3: When `ld_funct3` = 3'b100 (unsigned byte load), `ld_result[7:0]` is the selected byte and bits 31:8 are zero.
- R4: When `ld_funct3` = 3'b001 (signed halfword load), `ld_result[15:0]` is the selected halfword and bits 31:16 are copies of its bit 15.
- R5: When `ld_funct3` = 3'b101 (unsigned halfword load), `ld_result[15:0]` is the selected halfword and bits 31:16 are zero.
- R6: For byte loads, `byte_off` picks the lane: 0 selects `mem_word[7:0]`, 1 selects [15:8], 2 selects [23:16] and 3 selects [31:24].
- R7: For halfword loads, `byte_off[1]` = 0 selects `mem_word[15:0]` and `byte_off[1]` = 1 selects [31:16]. `byte_off[0]` has no effect on the result.
- R8: For the codes 3'b011, 3'b110 and 3'b111, `ld_result` equals `mem_word`.
- R9: For word loads and for the codes named in R8, `byte_off` has no effect on `ld_result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_word | input | 32 | Aligned word read from data memory |
| byte_off | input | 2 | Low two bits of the load byte address |
| ld_funct3 | input | 3 | Load function code giving size and signedness |
| ld_result | output | 32 | Extracted and extended value for writeback |

## Verification
Each code is applied with words whose lanes all hold different values, so that choosing the wrong lane or half changes the result. Words in which every lane has its top bit set, and words in which every lane has it clear, separate sign extension from zero extension. Each such word is applied with all four offsets. Odd offsets on halfword loads show that bit 0 of the offset is ignored. Every offset on word loads and on the undefined codes shows that the offset is ignored there as well. A long run of pseudo-random words, offsets and codes is then compared against a behavioural model on every clock.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  localparam int XLEN   = 32;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int LANES  = XLEN / BYTE_W;
  localparam int HALVES = XLEN / HALF_W;
  localparam int OFF_W  = $clog2(LANES);

  localparam logic [2:0] F3_LB  = 3'b000;
  localparam logic [2:0] F3_LH  = 3'b001;
  localparam logic [2:0] F3_LW  = 3'b010;
  localparam logic [2:0] F3_LBU = 3'b100;
  localparam logic [2:0] F3_LHU = 3'b101;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} ld_size_e;

  typedef struct packed {
    ld_size_e size;
    logic     signed_ld;
  } ld_ctl_t;

  function automatic ld_ctl_t decode_f3(input logic [2:0] f3);
    ld_ctl_t c;
    c.size      = SZ_WORD;
    c.signed_ld = 1'b0;
    case (f3)
      F3_LB:  begin c.size = SZ_BYTE; c.signed_ld = 1'b1; end
      F3_LH:  begin c.size = SZ_HALF; c.signed_ld = 1'b1; end
      F3_LBU: c.size = SZ_BYTE;
      F3_LHU: c.size = SZ_HALF;
      default: c.size = SZ_WORD;
    endcase
    return c;
  endfunction

  function automatic logic [XLEN-1:0] widen_byte(input logic [BYTE_W-1:0] b, input logic sgn);
    return {{(XLEN-BYTE_W){sgn & b[BYTE_W-1]}}, b};
  endfunction

  function automatic logic [XLEN-1:0] widen_half(input logic [HALF_W-1:0] h, input logic sgn);
    return {{(XLEN-HALF_W){sgn & h[HALF_W-1]}}, h};
  endfunction
endpackage

// File: rtl/ldx_lane_pick.sv
module ldx_lane_pick
  import ldx_pkg::*;
(
  input  logic [XLEN-1:0]   word_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [HALF_W-1:0] half_o,
  output logic [LANES-1:0]  byte_hit_o,
  output logic [HALVES-1:0] half_hit_o
);
  localparam int HSEL_W = (OFF_W > 1) ? OFF_W - 1 : 1;

  logic [HSEL_W-1:0] half_idx;
  assign half_idx = HSEL_W'(off_i >> 1);

  for (genvar i = 0; i < LANES; i++) begin : g_byte_hit
    assign byte_hit_o[i] = (off_i == OFF_W'(i));
  end

  for (genvar j = 0; j < HALVES; j++) begin : g_half_hit
    assign half_hit_o[j] = (half_idx == HSEL_W'(j));
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < LANES; i++) begin
      byte_o = byte_o | ({BYTE_W{byte_hit_o[i]}} & word_i[i*BYTE_W +: BYTE_W]);
    end
  end

  always_comb begin
    half_o = '0;
    for (int j = 0; j < HALVES; j++) begin
      half_o = half_o | ({HALF_W{half_hit_o[j]}} & word_i[j*HALF_W +: HALF_W]);
    end
  end

  always_comb begin
    if (!$isunknown(off_i)) begin
      AST_LANE_ONEHOT: assert ($onehot(byte_hit_o)) else $error("byte lane select not one-hot"); // R6
      AST_HALF_ONEHOT: assert ($onehot(half_hit_o)) else $error("half select not one-hot"); // R7
    end
  end
endmodule

// File: rtl/ldx_extend.sv
module ldx_extend
  import ldx_pkg::*;
(
  input  ld_ctl_t           ctl_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [XLEN-1:0]   word_i,
  output logic [XLEN-1:0]   result_o
);
  always_comb begin
    case (ctl_i.size)
      SZ_BYTE: result_o = widen_byte(byte_i, ctl_i.signed_ld);
      SZ_HALF: result_o = widen_half(half_i, ctl_i.signed_ld);
      default: result_o = word_i;
    endcase
  end
endmodule

// File: rtl/ld_extend_unit.sv
module ld_extend_unit
  import ldx_pkg::*;
(
  input  logic [XLEN-1:0]  mem_word,
  input  logic [OFF_W-1:0] byte_off,
  input  logic [2:0]       ld_funct3,
  output logic [XLEN-1:0]  ld_result
);
  ld_ctl_t           ctl;
  logic [BYTE_W-1:0] picked_byte;
  logic [HALF_W-1:0] picked_half;
  logic [LANES-1:0]  byte_hit;
  logic [HALVES-1:0] half_hit;

  assign ctl = decode_f3(ld_funct3);

  ldx_lane_pick u_pick (
    .word_i     (mem_word),
    .off_i      (byte_off),
    .byte_o     (picked_byte),
    .half_o     (picked_half),
    .byte_hit_o (byte_hit),
    .half_hit_o (half_hit)
  );

  ldx_extend u_ext (
    .ctl_i    (ctl),
    .byte_i   (picked_byte),
    .half_i   (picked_half),
    .word_i   (mem_word),
    .result_o (ld_result)
  );

  always_comb begin
    if (!$isunknown({mem_word, byte_off, ld_funct3})) begin
      if (ld_funct3 == F3_LW)
        AST_WORD_PASS: assert (ld_result == mem_word) else $error("word load altered"); // R1
      if (ld_funct3 == F3_LB)
        AST_SEXT_BYTE: assert (ld_result[XLEN-1:BYTE_W] == {(XLEN-BYTE_W){ld_result[BYTE_W-1]}}) else $error("byte sign fill"); // R2
      if (ld_funct3 == F3_LBU)
        AST_ZEXT_BYTE: assert (ld_result[XLEN-1:BYTE_W] == '0) else $error("byte zero fill"); // R3
      if (ld_funct3 == F3_LH)
        AST_SEXT_HALF: assert (ld_result[XLEN-1:HALF_W] == {(XLEN-HALF_W){ld_result[HALF_W-1]}}) else $error("half sign fill"); // R4
      if (ld_funct3 == F3_LHU)
        AST_ZEXT_HALF: assert (ld_result[XLEN-1:HALF_W] == '0) else $error("half zero fill"); // R5
      if (ld_funct3 == 3'b011 || ld_funct3 == 3'b110 || ld_funct3 == 3'b111)
        AST_UNDEF_RAW: assert (ld_result == mem_word) else $error("undefined code altered word"); // R8
    end
  end
endmodule

// File: tb/sim_ld_extend_unit.sv
module sim_ld_extend_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_word = '0;
  logic [1:0]  byte_off = '0;
  logic [2:0]  ld_funct3 = 3'b010;
  logic [31:0] ld_result;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ld_extend_unit u0 (
    .mem_word  (mem_word),
    .byte_off  (byte_off),
    .ld_funct3 (ld_funct3),
    .ld_result (ld_result)
  );

  function automatic logic [31:0] model(input logic [31:0] w, input int off, input int f3);
    longint b, h;
    b = (longint'(w) >> (off * 8)) & 255;
    h = (longint'(w) >> ((off / 2) * 16)) & 65535;
    case (f3)
      0: return (b >= 128) ? 32'(b - 256) : 32'(b);
      1: return (h >= 32768) ? 32'(h - 65536) : 32'(h);
      4: return 32'(b);
      5: return 32'(h);
      default: return w;
    endcase
  endfunction

  function automatic string req_of(input int f3, input int off);
    case (f3)
      0: return (off != 0) ? "R2/R6" : "R2";
      1: return (off % 2 == 1) ? "R4/R7" : "R4";
      2: return (off != 0) ? "R1/R9" : "R1";
      4: return (off != 0) ? "R3/R6" : "R3";
      5: return (off % 2 == 1) ? "R5/R7" : "R5";
      default: return (off != 0) ? "R8/R9" : "R8";
    endcase
  endfunction

  task automatic apply(input logic [31:0] w, input int off, input int f3);
    logic [31:0] exp;
    @(negedge clk);
    mem_word  = w;
    byte_off  = 2'(off);
    ld_funct3 = 3'(f3);
    exp = model(w, off, f3);
    @(posedge clk);
    #1;
    n_vec++;
    if (ld_result !== exp) begin
      n_bad++;
      $display("FAIL %s f3=%0d off=%0d word=%h actual=%h expected=%h",
               req_of(f3, off), f3, off, w, ld_result, exp);
    end
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // initial state: zero word, word load gives zero (R1)
    apply(32'h0, 0, 2);
    // distinct lanes, high bits set / clear: R1..R9 over every offset
    for (int f3 = 0; f3 < 8; f3++) begin
      for (int off = 0; off < 4; off++) begin
        apply(32'h8C_B4_F0_91, off, f3);
        apply(32'h12_34_56_78, off, f3);
        apply(32'h7F_80_01_FF, off, f3);
      end
    end
    // boundary: 0x80 and 0x7F bytes, 0x8000 and 0x7FFF halves (R2..R5)
    apply(32'h0000_0080, 0, 0);
    apply(32'h0000_007F, 0, 0);
    apply(32'h8000_0000, 2, 1);
    apply(32'h7FFF_0000, 3, 1);
    apply(32'h8000_0000, 3, 5);
    apply(32'hFF00_0000, 3, 4);
    lfsr = 32'hACE1_1357;
    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr ^ (lfsr << 7), int'(lfsr[9:8]), int'(lfsr[14:12]));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule